// File: doc/BRIEF.md
# Indirect General-Purpose I/O Controller

This block controls 22 general-purpose pins arranged in three groups: pins 10-17, pins 20-25 and pins 30-37. Pin data is never mapped directly onto the 8-bit I/O bus. Software first writes a register number into an index port. It then reads or writes that register through a companion data port. A port-selection register in a separate configuration space turns this port pair on and moves it to one of four bus locations.

Each pin has its own configuration register. It holds a direction bit, a polarity-inversion bit and a special-function bit. When the special-function bit is set, the pin is handed to an alternate-function unit outside this block. That unit then owns the pin's driven value and enable, and it receives the pin's sampled level.

Pin levels pass through a synchronizer before software can read them. Reading a data register returns what is actually on the pins, not the output latch. Software therefore changes one output bit by reading the register, modifying the bit and writing the value back.

Top module: `gpio_indirect_ctrl`

## Requirements
- R1: After reset, the following hold:
  - every pin is an input with pin_oe low, non-inverted and in normal function, so each per-pin config register reads 0x01;
  - the port-selection register reads 0x00;
  - bus reads return 0xFF.
- R2: The port-selection register sits at config address 0x03. Its bits 1-0 place the index/data port pair:
  - value 0 places it at 0xE0/0xE1;
  - value 1 at 0xE2/0xE3;
  - value 2 at 0xE4/0xE5;
  - value 3 at 0xEA/0xEB.
  The index port reads back the last index written.
- R3: Bit 7 of the port-selection register enables the pair. While bit 7 is clear, or for any bus address outside the selected pair, writes are ignored and reads return 0xFF.
- R4: Index 0x01 selects the data of pins 10-17, 0x02 pins 20-25 and 0x03 pins 30-37, with data bit n belonging to the group's first pin plus n. Any other index reads 0x00 through the data port and ignores writes.
- R5: In the pins 20-25 data register, bits 7-6 always read 0.
- R6: Config bit 0 set makes a normal-function pin an input with pin_oe low. Clear, the pin drives its output latch with pin_oe high.
- R7: Config bit 1 set inverts the pin. The driven value is the latch inverted, and the level read back is the pad level inverted.
- R8: Config bit 3 set hands the pin to its special function:
  - pin_out and pin_oe follow alt_out and alt_oe;
  - alt_in carries the synchronized pad level;
  - data-register writes leave that pin's output latch unchanged.
- R9: Per-pin config registers sit at config address 0xE0+n for pins 10-17, 0xE8+n for pins 20-25 and 0xF5+n for pins 30-37. Only bits 0, 1 and 3 are stored, and other bits read 0. Unmapped config addresses read 0x00.
- R10: A data-register read returns the synchronized pin levels, after a latency of SYNC_STAGES cycles, rather than the output latch. A read-modify-write therefore changes only the intended output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | I/O bus address |
| bus_wdata | input | 8 | I/O bus write data |
| bus_wr | input | 1 | I/O bus write strobe |
| bus_rd | input | 1 | I/O bus read strobe |
| bus_rdata | output | 8 | I/O bus read data |
| cfg_addr | input | 8 | Configuration space address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | 8 | Configuration read data |
| pin_in | input | 22 | Pad levels, bit 0 = pin 10 up to bit 21 = pin 37 |
| pin_out | output | 22 | Pad drive values |
| pin_oe | output | 22 | Pad output enables |
| alt_out | input | 22 | Alternate-function drive values |
| alt_oe | input | 22 | Alternate-function output enables |
| alt_in | output | 22 | Pad levels for pins in special function, 0 otherwise |

## Verification
The hardest situation to reach from the ports is a data-register write landing on a pin that is in special function. While the pin is special, pin_out shows alt_out, so the held latch value cannot be seen. The stimulus writes a value to the group with the pin special, then returns the pin to normal output mode. The pin must then drive the value it held before the write. The read path is checked with a pad model that loops driven pins back to their inputs. This lets a read-modify-write show both the inversion on both sides and the synchronizer latency.

// File: rtl/gpio_ind_pkg.sv
package gpio_ind_pkg;
  localparam int NPIN = 22;
  localparam int NGRP = 3;
  localparam logic [7:0] SEL_CFG_ADDR = 8'h03;
  localparam logic [7:0] IDLE_RDATA = 8'hFF;

  // Bus address of the index port for each placement code
  function automatic logic [7:0] pair_base(input logic [1:0] pos);
    case (pos)
      2'd0: pair_base = 8'hE0;
      2'd1: pair_base = 8'hE2;
      2'd2: pair_base = 8'hE4;
      default: pair_base = 8'hEA;
    endcase
  endfunction

  function automatic int grp_size(input int g);
    return (g == 1) ? 6 : 8;
  endfunction

  function automatic int grp_first(input int g);
    return (g == 0) ? 0 : (g == 1) ? 8 : 14;
  endfunction

  function automatic logic [7:0] grp_cfg_base(input int g);
    return (g == 0) ? 8'hE0 : (g == 1) ? 8'hE8 : 8'hF5;
  endfunction

  function automatic logic [1:0] pin_grp(input int p);
    return (p < 8) ? 2'd0 : (p < 14) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [2:0] pin_bit(input int p);
    int b;
    b = p - grp_first(int'(pin_grp(p)));
    return b[2:0];
  endfunction
endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_ind_pkg::*;
(
  input  logic       sel_en,
  input  logic [1:0] sel_pos,
  input  logic [7:0] addr,
  output logic       hit_idx,
  output logic       hit_dat
);
  logic [7:0] base;

  assign base    = pair_base(sel_pos);
  assign hit_idx = sel_en && (addr == base);
  assign hit_dat = sel_en && (addr == (base + 8'd1));
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_ind_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            cfg_we,
  output logic [7:0]      cfg_rdata,
  output logic            sel_en,
  output logic [1:0]      sel_pos,
  output logic [NPIN-1:0] inp,
  output logic [NPIN-1:0] inv,
  output logic [NPIN-1:0] spec
);
  logic       sel_en_q, sel_en_d;
  logic [1:0] sel_pos_q, sel_pos_d;
  logic       sel_wr;
  logic [7:0] pin_addr [NPIN];

  assign sel_wr = cfg_we && (cfg_addr == SEL_CFG_ADDR);

  always_comb begin
    sel_en_d  = sel_en_q;
    sel_pos_d = sel_pos_q;
    if (sel_wr) begin
      sel_en_d  = cfg_wdata[7];
      sel_pos_d = cfg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_en_q  <= 1'b0;
      sel_pos_q <= 2'd0;
    end else begin
      sel_en_q  <= sel_en_d;
      sel_pos_q <= sel_pos_d;
    end
  end

  assign sel_en  = sel_en_q;
  assign sel_pos = sel_pos_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar n = 0; n < grp_size(g); n++) begin : g_pin
      localparam int P = grp_first(g) + n;
      localparam logic [7:0] A = grp_cfg_base(g) + 8'(n);
      logic hit, inp_q, inv_q, spec_q;

      assign hit = cfg_we && (cfg_addr == A);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          inp_q  <= 1'b1;
          inv_q  <= 1'b0;
          spec_q <= 1'b0;
        end else if (hit) begin
          inp_q  <= cfg_wdata[0];
          inv_q  <= cfg_wdata[1];
          spec_q <= cfg_wdata[3];
        end
      end

      assign pin_addr[P] = A;
      assign inp[P]  = inp_q;
      assign inv[P]  = inv_q;
      assign spec[P] = spec_q;
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_addr == SEL_CFG_ADDR) cfg_rdata = {sel_en_q, 5'b0, sel_pos_q};
    for (int p = 0; p < NPIN; p++) begin
      if (cfg_addr == pin_addr[p]) cfg_rdata = {4'b0, spec[p], 1'b0, inv[p], inp[p]};
    end
  end

  p_sel_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel_pos == $past(cfg_wdata[1:0])) && (sel_en == $past(cfg_wdata[7])));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 22,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_ind_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] inp,
  input  logic [NPIN-1:0] inv,
  input  logic [NPIN-1:0] spec,
  input  logic [NPIN-1:0] olat,
  input  logic [NPIN-1:0] pad_sync,
  input  logic [NPIN-1:0] alt_out,
  input  logic [NPIN-1:0] alt_oe,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] alt_in,
  output logic [NPIN-1:0] level
);
  for (genvar p = 0; p < NPIN; p++) begin : g_mux
    assign pin_out[p] = spec[p] ? alt_out[p] : (olat[p] ^ inv[p]);
    assign pin_oe[p]  = spec[p] ? alt_oe[p]  : ~inp[p];
    assign alt_in[p]  = spec[p] & pad_sync[p];
    assign level[p]   = spec[p] ? pad_sync[p] : (pad_sync[p] ^ inv[p]);
  end

  p_input_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((inp & ~spec & pin_oe) == '0));
  p_spec_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_out ^ alt_out) & spec) == '0) && (((pin_oe ^ alt_oe) & spec) == '0));
endmodule

// File: rtl/gpio_indirect_ctrl.sv
module gpio_indirect_ctrl
  import gpio_ind_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  output logic [7:0]      bus_rdata,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            cfg_we,
  output logic [7:0]      cfg_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NPIN-1:0] alt_out,
  input  logic [NPIN-1:0] alt_oe,
  output logic [NPIN-1:0] alt_in
);
  logic [1:0]      rst_pipe;
  logic            srst_n;
  logic            sel_en, hit_idx, hit_dat, dat_wr;
  logic [1:0]      sel_pos;
  logic [NPIN-1:0] inp, inv, spec, pad_sync, level;
  logic [NPIN-1:0] olat_q, olat_d;
  logic [7:0]      idx_q, idx_d;
  logic [7:0]      lvl_byte [NGRP];

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  gpio_cfg_bank u_cfg (
    .clk(clk), .rst_n(srst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .sel_en(sel_en), .sel_pos(sel_pos),
    .inp(inp), .inv(inv), .spec(spec)
  );

  gpio_port_decode u_dec (
    .sel_en(sel_en), .sel_pos(sel_pos), .addr(bus_addr),
    .hit_idx(hit_idx), .hit_dat(hit_dat)
  );

  gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(pin_in), .q(pad_sync)
  );

  gpio_pin_mux u_mux (
    .clk(clk), .rst_n(srst_n), .inp(inp), .inv(inv), .spec(spec), .olat(olat_q),
    .pad_sync(pad_sync), .alt_out(alt_out), .alt_oe(alt_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_in(alt_in), .level(level)
  );

  assign dat_wr = bus_wr && hit_dat;

  always_comb begin
    idx_d  = idx_q;
    olat_d = olat_q;
    if (bus_wr && hit_idx) idx_d = bus_wdata;
    if (dat_wr) begin
      for (int p = 0; p < NPIN; p++) begin
        if ((idx_q == (8'(pin_grp(p)) + 8'd1)) && !spec[p]) olat_d[p] = bus_wdata[pin_bit(p)];
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      idx_q  <= 8'h00;
      olat_q <= '0;
    end else begin
      idx_q  <= idx_d;
      olat_q <= olat_d;
    end
  end

  always_comb begin
    for (int g = 0; g < NGRP; g++) lvl_byte[g] = 8'h00;
    for (int p = 0; p < NPIN; p++) lvl_byte[pin_grp(p)][pin_bit(p)] = level[p];
  end

  always_comb begin
    bus_rdata = IDLE_RDATA;
    if (hit_idx) begin
      bus_rdata = idx_q;
    end else if (hit_dat) begin
      case (idx_q)
        8'h01:   bus_rdata = lvl_byte[0];
        8'h02:   bus_rdata = lvl_byte[1];
        8'h03:   bus_rdata = lvl_byte[2];
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  p_idle_read_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && !sel_en) |-> (bus_rdata == 8'hFF));
  p_grp2_top_zero_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && hit_dat && idx_q == 8'h02) |-> (bus_rdata[7:6] == 2'b00));
  p_spec_latch_hold_r8: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (((olat_q ^ $past(olat_q)) & $past(spec)) == '0));
endmodule

// File: tb/sim_gpio_indirect_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_indirect_ctrl;
  localparam int NP = 22;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr, bus_wdata, bus_rdata, cfg_addr, cfg_wdata, cfg_rdata;
  logic          bus_wr, bus_rd, cfg_we;
  logic [NP-1:0] pin_in, pin_out, pin_oe, alt_out, alt_oe, alt_in, ext_in;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;
  sb_item_t      sb_q [$];

  always #2 clk = ~clk;

  // pad model: a driven pin reads back its own output
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  gpio_indirect_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: compares each read against the queued expectation
  always begin
    @(posedge clk);
    #1;
    if (bus_rd) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow actual=%0h expected=none", bus_rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0; bus_rd = 1'b0;
    cfg_addr = 8'h00; cfg_wdata = 8'h00; cfg_we = 1'b0;
    ext_in = '0; alt_out = '0; alt_oe = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    check("R1 pin_oe after reset", 32'(pin_oe), 32'h0);
    cfg_check(8'hE0, 8'h01, "R1 pin10 cfg reset");
    cfg_check(8'h03, 8'h00, "R1 sel reset");
    bus_read(8'hE0, 8'hFF, "R1 disabled read");

    // R3 disabled port ignores writes
    bus_write(8'hE0, 8'h02);
    cfg_write(8'h03, 8'h80);
    bus_read(8'hE0, 8'h00, "R3 index write ignored while disabled");
    bus_write(8'hE0, 8'h01);
    bus_read(8'hE0, 8'h01, "R2 index readback at E0");
    bus_read(8'hE2, 8'hFF, "R3 outside pair");

    // R2 relocation over all placements
    cfg_write(8'h03, 8'h81);
    bus_read(8'hE2, 8'h01, "R2 pair at E2");
    bus_read(8'hE0, 8'hFF, "R3 old pair dead");
    cfg_write(8'h03, 8'h82);
    bus_read(8'hE4, 8'h01, "R2 pair at E4");
    cfg_write(8'h03, 8'h83);
    bus_read(8'hEA, 8'h01, "R2 pair at EA");
    bus_read(8'hE4, 8'hFF, "R3 E4 outside");

    // R6/R4 group 1 as outputs
    for (int n = 0; n < 8; n++) cfg_write(8'hE0 + 8'(n), 8'h00);
    bus_write(8'hEB, 8'hA5);
    @(negedge clk);
    check("R6 group1 oe", 32'(pin_oe[7:0]), 32'hFF);
    check("R4 group1 out", 32'(pin_out[7:0]), 32'hA5);
    settle();
    bus_read(8'hEB, 8'hA5, "R10 loopback read");

    // R4 group 3 inputs, R5 group 2
    ext_in[21:14] = 8'h3C;
    ext_in[13:8]  = 6'h3F;
    settle();
    bus_write(8'hEA, 8'h03);
    bus_read(8'hEB, 8'h3C, "R4 group3 bit map");
    bus_write(8'hEA, 8'h02);
    bus_read(8'hEB, 8'h3F, "R5 group2 top bits zero");

    // R7 inversion
    cfg_write(8'hF5, 8'h03);
    settle();
    bus_write(8'hEA, 8'h03);
    bus_read(8'hEB, 8'h3D, "R7 input inversion pin30");
    cfg_write(8'hE0, 8'h02);
    @(negedge clk);
    check("R7 output inversion pin10", 32'(pin_out[0]), 32'h0);
    settle();
    bus_write(8'hEA, 8'h01);
    bus_read(8'hEB, 8'hA5, "R7 inverted pin reads latch");

    // R8 special function
    alt_out[1] = 1'b1; alt_oe[1] = 1'b0; ext_in[1] = 1'b1;
    cfg_write(8'hE1, 8'h08);
    @(negedge clk);
    check("R8 special out", 32'(pin_out[1]), 32'h1);
    check("R8 special oe", 32'(pin_oe[1]), 32'h0);
    settle();
    check("R8 alt_in", 32'(alt_in[1]), 32'h1);
    check("R8 alt_in normal pins", 32'(alt_in & ~22'h2), 32'h0);
    bus_write(8'hEB, 8'hFF);
    cfg_write(8'hE1, 8'h00);
    @(negedge clk);
    check("R8 latch held through special", 32'(pin_out[1]), 32'h0);
    check("R8 others took write", 32'(pin_out[7:2]), 32'h3F);

    // R10 read-modify-write
    settle();
    bus_read(8'hEB, 8'hFD, "R10 levels before rmw");
    bus_write(8'hEB, 8'hFD & 8'h7F);
    @(negedge clk);
    check("R10 rmw cleared pin17", 32'(pin_out[7]), 32'h0);
    settle();
    bus_read(8'hEB, 8'h7D, "R10 levels after rmw");

    // R4 unimplemented index
    bus_write(8'hEA, 8'h05);
    bus_read(8'hEB, 8'h00, "R4 unknown index reads 0");
    bus_write(8'hEB, 8'h00);
    bus_write(8'hEA, 8'h01);
    bus_read(8'hEB, 8'h7D, "R4 unknown index write ignored");

    // R9 config map
    cfg_check(8'hE7, 8'h00, "R9 pin17 cfg");
    cfg_write(8'hE8, 8'hFF);
    cfg_check(8'hE8, 8'h0B, "R9 pin20 stored bits");
    cfg_check(8'hEE, 8'h00, "R9 unmapped EE");
    cfg_check(8'hF4, 8'h00, "R9 unmapped F4");
    cfg_write(8'hFC, 8'h02);
    cfg_check(8'hFC, 8'h02, "R9 pin37 cfg");
    alt_out[8] = 1'b1; alt_oe[8] = 1'b1;
    @(negedge clk);
    check("R9 pin20 special via E8", 32'({pin_oe[8], pin_out[8]}), 32'h3);

    // R3 writes while disabled
    cfg_write(8'h03, 8'h03);
    bus_write(8'hEB, 8'h00);
    bus_write(8'hEA, 8'h02);
    bus_read(8'hEB, 8'hFF, "R3 data read disabled");
    cfg_write(8'h03, 8'h83);
    bus_read(8'hEA, 8'h01, "R3 index kept");
    settle();
    bus_read(8'hEB, 8'h7D, "R3 data kept");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule